// File: doc/BRIEF.md
# HDLC Receive Deframer

This block takes a serial line, one bit per cycle in which `bit_en` is high, and recovers HDLC frames from it. It looks for the 0x7E flag. It removes the zero that a transmitter inserts after five ones, and packs the remaining bits into octets, least significant bit first. It runs the frame check sequence over every octet between the flags. Each frame ends with a single verdict pulse. The pulse says whether the frame is good, and if it is not, which of four rejection rules it broke.

Payload octets leave the block two octets late. This delay means the two FCS octets at the end of a frame never appear as payload. The first payload octet of a frame carries a start marker, and the verdict pulse marks the end of the frame. Downstream logic writes the octets as they arrive and then keeps or drops the frame according to the verdict.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, every output is low and the receiver is hunting. Bits that arrive before the first 0x7E flag produce no octet and no verdict.
- R2: A zero that arrives after five consecutive ones is removed. It is counted neither in the data nor in the bit length.
- R3: Octets are packed least significant bit first. For a frame of N octets between its flags, exactly N-2 octets are presented on `oct_valid`, and the two FCS octets are withheld. `oct_sof` is high on the first of these octets only.
- R4: Each closed frame that holds at least one complete octet gives exactly one `frame_done` pulse. `frame_good` is high on that pulse exactly when no error flag is set. A verdict never coincides with an octet output.
- R5: The FCS uses a reflected register with feedback 0x8408, preset to 0xFFFF, fed LSB first over every octet between the flags. The sender appends the ones' complement of its register, low byte first. Any final register value other than 0xF0B8 sets `err_fcs`.
- R6: A frame with fewer than 5 octets between its flags (FCS included, flags excluded) sets `err_short`.
- R7: A frame whose unstuffed bit length between its flags is not a multiple of 8 sets `err_align`.
- R8: Seven consecutive ones inside a frame end it. The verdict pulse then has `err_abort` set and no other error flag. Until the next flag, no further octet or verdict is produced.
- R9: Adjacent flags produce no verdict, including two flags that share one zero. A closing flag also opens the next frame.
- R10: Outputs pulse only in the cycle after a cycle in which `bit_en` was high. Cycles with `bit_en` low leave the receive state unchanged, whatever `bit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Line bit valid this cycle |
| bit_in | input | 1 | Serial line bit |
| oct_valid | output | 1 | Payload octet presented |
| oct_data | output | 8 | Payload octet |
| oct_sof | output | 1 | First payload octet of a frame |
| frame_done | output | 1 | End-of-frame verdict pulse |
| frame_good | output | 1 | Frame accepted |
| err_fcs | output | 1 | FCS residue wrong |
| err_short | output | 1 | Fewer than 5 octets |
| err_align | output | 1 | Length not whole octets |
| err_abort | output | 1 | Frame aborted |

## Verification
The bench sends payloads that contain 0xFF, 0x7E and 0x3F, so stuffing occurs in the middle of octets. A design that failed to remove the stuffed zeros would shift later octets and report FCS errors. A misaligned frame carries three extra bits before its flag, which a design that counted only whole octets would accept as good. Further scenarios cover an abort followed by garbage, two flags sharing one zero, one flag closing a frame and opening the next, and bit gaps with a toggling line. A design that got these wrong would emit stray verdicts, lose the second frame, or pick up bits while `bit_en` is low.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam logic [15:0] FCS_PRESET   = 16'hFFFF;
    localparam logic [15:0] FCS_FEEDBACK = 16'h8408;
    localparam logic [15:0] FCS_GOOD     = 16'hF0B8;
    localparam int          FCS_OCTETS   = 2;
    // data bits that leak out of a closing flag before it is recognised
    localparam int          FLAG_LEAK    = 6;
    localparam int          STUFF_RUN    = 5;
endpackage

// File: rtl/hdlc_bit_unstuff.sv
module hdlc_bit_unstuff
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic data_vld,
    output logic data_bit,
    output logic flag_evt,
    output logic abort_evt
);
    localparam int RUN_W = 3;
    localparam logic [RUN_W-1:0] RUN_SAT  = '1;
    localparam logic [RUN_W-1:0] RUN_STUF = RUN_W'(STUFF_RUN);
    localparam logic [RUN_W-1:0] RUN_FLAG = RUN_W'(STUFF_RUN + 1);

    logic [RUN_W-1:0] ones_d, ones_q;

    always_comb begin
        ones_d    = ones_q;
        data_vld  = 1'b0;
        flag_evt  = 1'b0;
        abort_evt = 1'b0;
        data_bit  = bit_in;
        if (bit_en) begin
            data_vld = (ones_q < RUN_STUF);
            if (bit_in) begin
                if (ones_q != RUN_SAT) ones_d = ones_q + 1'b1;
                abort_evt = (ones_q == RUN_FLAG);
            end else begin
                ones_d   = '0;
                flag_evt = (ones_q == RUN_FLAG);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ones_q));
endmodule

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] octet,
    output logic       fcs_ok
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = FCS_PRESET;
        end else if (upd) begin
            for (int i = 0; i < 8; i++) begin
                if (crc_d[0] ^ octet[i]) crc_d = (crc_d >> 1) ^ FCS_FEEDBACK;
                else                     crc_d = crc_d >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= FCS_PRESET;
        else        crc_q <= crc_d;
    end

    assign fcs_ok = (crc_q == FCS_GOOD);

    // R5
    preset_not_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fcs_ok);
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int MIN_OCTETS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       oct_valid,
    output logic [7:0] oct_data,
    output logic       oct_sof,
    output logic       frame_done,
    output logic       frame_good,
    output logic       err_fcs,
    output logic       err_short,
    output logic       err_align,
    output logic       err_abort
);
    localparam int CNT_W = $clog2(MIN_OCTETS + 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;
    localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_OCTETS);
    localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(FCS_OCTETS);
    localparam logic [2:0]       BIT_LEAK = 3'(FLAG_LEAK);

    typedef struct packed {
        logic                             in_frame;
        logic [7:0]                       sr;
        logic [2:0]                       bcnt;
        logic [CNT_W-1:0]                 noct;
        logic [FCS_OCTETS-1:0][7:0]       hold;
        logic                             ov;
        logic [7:0]                       od;
        logic                             osof;
        logic                             done;
        logic                             good;
        logic                             e_fcs;
        logic                             e_short;
        logic                             e_align;
        logic                             e_abort;
    } rx_state_t;

    rx_state_t s_d, s_q;

    logic data_vld, data_bit, flag_evt, abort_evt;
    logic crc_clr, crc_upd, fcs_ok;
    logic [7:0] octet_new;

    hdlc_bit_unstuff i_unstuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .data_vld  (data_vld),
        .data_bit  (data_bit),
        .flag_evt  (flag_evt),
        .abort_evt (abort_evt)
    );

    hdlc_fcs16 i_fcs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .upd    (crc_upd),
        .octet  (octet_new),
        .fcs_ok (fcs_ok)
    );

    assign octet_new = {data_bit, s_q.sr[7:1]};

    always_comb begin
        s_d         = s_q;
        s_d.ov      = 1'b0;
        s_d.osof    = 1'b0;
        s_d.done    = 1'b0;
        s_d.good    = 1'b0;
        s_d.e_fcs   = 1'b0;
        s_d.e_short = 1'b0;
        s_d.e_align = 1'b0;
        s_d.e_abort = 1'b0;
        crc_clr     = 1'b0;
        crc_upd     = 1'b0;
        if (abort_evt) begin
            if (s_q.in_frame && s_q.noct != '0) begin
                s_d.done    = 1'b1;
                s_d.e_abort = 1'b1;
            end
            s_d.in_frame = 1'b0;
            s_d.bcnt     = '0;
            s_d.noct     = '0;
            crc_clr      = 1'b1;
        end else if (flag_evt) begin
            if (s_q.in_frame && s_q.noct != '0) begin
                s_d.done    = 1'b1;
                s_d.e_fcs   = !fcs_ok;
                s_d.e_short = (s_q.noct < CNT_MIN);
                s_d.e_align = (s_q.bcnt != BIT_LEAK);
                s_d.good    = fcs_ok && (s_q.noct >= CNT_MIN) && (s_q.bcnt == BIT_LEAK);
            end
            s_d.in_frame = 1'b1;
            s_d.bcnt     = '0;
            s_d.noct     = '0;
            crc_clr      = 1'b1;
        end else if (data_vld && s_q.in_frame) begin
            s_d.sr   = octet_new;
            s_d.bcnt = s_q.bcnt + 1'b1;
            if (s_q.bcnt == 3'd7) begin
                crc_upd  = 1'b1;
                s_d.hold = {s_q.hold[FCS_OCTETS-2:0], octet_new};
                if (s_q.noct != CNT_SAT) s_d.noct = s_q.noct + 1'b1;
                if (s_q.noct >= CNT_HOLD) begin
                    s_d.ov   = 1'b1;
                    s_d.od   = s_q.hold[FCS_OCTETS-1];
                    s_d.osof = (s_q.noct == CNT_HOLD);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign oct_valid  = s_q.ov;
    assign oct_data   = s_q.od;
    assign oct_sof    = s_q.osof;
    assign frame_done = s_q.done;
    assign frame_good = s_q.good;
    assign err_fcs    = s_q.e_fcs;
    assign err_short  = s_q.e_short;
    assign err_align  = s_q.e_align;
    assign err_abort  = s_q.e_abort;

    // R4
    good_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_good |-> frame_done && !err_fcs && !err_short && !err_align && !err_abort);
    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(oct_valid && frame_done));
    // R8
    abort_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_abort |-> frame_done && !err_fcs && !err_short && !err_align);
    // R3
    sof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oct_sof |-> oct_valid);
    // R10
    pulse_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !oct_valid && !frame_done);
endmodule

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic oct_valid, oct_sof, frame_done, frame_good;
    logic err_fcs, err_short, err_align, err_abort;
    logic [7:0] oct_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] rx_data [64];
    int rx_n, done_n, sof_n, sof_pos, good_n;
    logic l_good, l_fcs, l_short, l_align, l_abort;
    logic [7:0] pl [16];
    int tx_ones = 0;
    int gap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_deframer i_hdlc_rx_deframer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .oct_valid(oct_valid), .oct_data(oct_data), .oct_sof(oct_sof),
        .frame_done(frame_done), .frame_good(frame_good), .err_fcs(err_fcs),
        .err_short(err_short), .err_align(err_align), .err_abort(err_abort)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (oct_valid) begin
                if (oct_sof) begin sof_n++; sof_pos = rx_n; end
                if (rx_n < 64) rx_data[rx_n] = oct_data;
                rx_n++;
            end
            if (frame_done) begin
                done_n++;
                if (frame_good) good_n++;
                l_good = frame_good; l_fcs = err_fcs; l_short = err_short;
                l_align = err_align; l_abort = err_abort;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rx();
        rx_n = 0; done_n = 0; sof_n = 0; sof_pos = -1; good_n = 0;
        l_good = 0; l_fcs = 0; l_short = 0; l_align = 0; l_abort = 0;
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1; bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        for (int g = 0; g < gap; g++) begin
            bit_in = ~bit_in;
            @(negedge clk);
        end
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_flag();
        send_raw(8'h7E);
        tx_ones = 0;
    endtask

    task automatic send_dbit(input logic b);
        send_bit(b);
        if (b) tx_ones++; else tx_ones = 0;
        if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
    endtask

    task automatic send_octet(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    task automatic send_body(input int len, input bit corrupt);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            c = crc_step(c, pl[i]);
            send_octet((i == 0 && corrupt) ? (pl[i] ^ 8'h01) : pl[i]);
        end
        c = ~c;
        send_octet(c[7:0]);
        send_octet(c[15:8]);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_payload(input int len, input string req);
        chk(rx_n == len, req, rx_n, len);
        for (int i = 0; i < len; i++)
            chk(rx_data[i] == pl[i], req, rx_data[i], pl[i]);
        chk(sof_n == 1 && sof_pos == 0, req, sof_pos, 0);
    endtask

    task automatic t_reset_hunt();
        chk({oct_valid, oct_sof, frame_done, frame_good, err_fcs, err_short, err_align, err_abort} == 8'h0,
            "R1 reset", 1, 0);
        clear_rx();
        send_raw(8'hAA); send_raw(8'h00); send_raw(8'h3C); send_raw(8'h81);
        settle();
        chk(rx_n == 0, "R1 hunt octets", rx_n, 0);
        chk(done_n == 0, "R1 hunt verdict", done_n, 0);
    endtask

    task automatic t_good_basic();
        clear_rx();
        pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'h56;
        send_flag(); send_body(3, 0); send_flag(); settle();
        check_payload(3, "R3 lsb-first payload");
        chk(done_n == 1 && l_good, "R4 good verdict", done_n, 1);
        chk(!l_fcs, "R5 fcs ok", l_fcs, 0);
    endtask

    task automatic t_stuffing();
        clear_rx();
        pl[0] = 8'hFF; pl[1] = 8'h7E; pl[2] = 8'h3F; pl[3] = 8'hF8; pl[4] = 8'h1F;
        send_flag(); send_body(5, 0); send_flag(); settle();
        check_payload(5, "R2 stuffed payload");
        chk(done_n == 1 && l_good, "R2 stuffed verdict", l_good, 1);
    endtask

    task automatic t_bad_fcs();
        clear_rx();
        pl[0] = 8'hA5; pl[1] = 8'h5A; pl[2] = 8'hC3; pl[3] = 8'h3C;
        send_flag(); send_body(4, 1); send_flag(); settle();
        chk(done_n == 1 && l_fcs, "R5 fcs error", l_fcs, 1);
        chk(!l_good && !l_short && !l_align, "R5 only fcs", l_good, 0);
    endtask

    task automatic t_short();
        clear_rx();
        pl[0] = 8'h01; pl[1] = 8'h02;
        send_flag(); send_body(2, 0); send_flag(); settle();
        chk(done_n == 1 && l_short, "R6 short", l_short, 1);
        chk(!l_fcs && !l_align && !l_good, "R6 short only", l_fcs, 0);
    endtask

    task automatic t_align();
        clear_rx();
        pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
        send_flag(); send_body(3, 0);
        send_dbit(1'b1); send_dbit(1'b0); send_dbit(1'b1);
        send_flag(); settle();
        chk(done_n == 1 && l_align, "R7 misaligned", l_align, 1);
        chk(!l_good, "R7 not good", l_good, 0);
    endtask

    task automatic t_abort();
        clear_rx();
        pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
        send_flag();
        send_octet(pl[0]); send_octet(pl[1]); send_octet(pl[2]);
        send_raw(8'hFF);
        settle();
        chk(done_n == 1 && l_abort, "R8 abort verdict", l_abort, 1);
        chk(!l_good && !l_fcs && !l_short && !l_align, "R8 abort only", l_fcs, 0);
        clear_rx();
        send_raw(8'h55); send_raw(8'hAA); send_raw(8'h0F);
        settle();
        chk(rx_n == 0 && done_n == 0, "R8 silent after abort", rx_n + done_n, 0);
        pl[0] = 8'hDE; pl[1] = 8'hAD; pl[2] = 8'hBE; pl[3] = 8'hEF;
        send_flag(); send_body(4, 0); send_flag(); settle();
        check_payload(4, "R8 recovery payload");
        chk(done_n == 1 && l_good, "R8 recovery good", l_good, 1);
    endtask

    task automatic t_flags();
        clear_rx();
        send_flag(); send_flag(); send_flag(); send_flag();
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        settle();
        chk(done_n == 0, "R9 idle flags", done_n, 0);
        pl[0] = 8'h42; pl[1] = 8'h24; pl[2] = 8'h99;
        tx_ones = 0;
        send_body(3, 0); send_flag(); send_body(3, 0); send_flag(); settle();
        chk(done_n == 2 && good_n == 2, "R9 shared flags", good_n, 2);
        chk(rx_n == 6, "R9 octet count", rx_n, 6);
        chk(sof_n == 2, "R3 sof per frame", sof_n, 2);
    endtask

    task automatic t_gaps();
        clear_rx();
        gap = 3;
        pl[0] = 8'h5A; pl[1] = 8'hFE; pl[2] = 8'h7D; pl[3] = 8'h00;
        send_flag(); send_body(4, 0); send_flag(); settle();
        gap = 0;
        check_payload(4, "R10 gapped payload");
        chk(done_n == 1 && l_good, "R10 gapped verdict", l_good, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_rx();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_hunt();
        t_good_basic();
        t_stuffing();
        t_bad_fcs();
        t_short();
        t_align();
        t_abort();
        t_flags();
        t_gaps();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule